// File: doc/BRIEF.md
# Exception Vector Priority Resolver

This block picks the exception a processor core should service next and hands back the 16-bit address of its vector. It watches three reset classes, two synchronous traps, the two external interrupt lines (a non-maskable-by-I line, XIRQ, and the ordinary IRQ) and a parameterised bank of peripheral interrupt lines. When the core pulses the vector request strobe, the block samples every source on that edge, resolves a strict fixed priority, forms the address and registers it. The address then stays put until the next request.

Reset classes return fixed addresses at the top of memory. Every other class returns the vector base page with an offset in the low byte. The base is taken from a register outside this block, and only its upper byte is used, so no adder is needed. A source that is already gone when the strobe arrives is not remembered. If nothing is still pending and unmasked on that edge, the block returns the spurious vector.

The request side has no back-pressure. A strobe is accepted on every cycle it is high, and the result appears as a one-cycle `vec_valid` pulse on the next cycle. The consumer must take the address during that pulse or read it later from the held output. The address stays valid until the next strobe.

Top module: `exc_vector_resolver`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe yet seen, `vec_valid` is 0 and `vec_addr` is 0x0000.
- R2: `vec_addr` changes only on the cycle after a clock edge with `vec_req` high. On every other cycle it holds its previous value.
- R3: `vec_valid` is 1 exactly on the cycle after each edge with `vec_req` high, and 0 otherwise.
- R4: Reset classes win over everything and ignore the base. `rst_por` gives 0xFFFE, then `rst_clkmon` gives 0xFFFC, then `rst_wdog` gives 0xFFFA, in that priority.
- R5: Traps come next and are never masked. `trap_opcode` gives base page + 0xF8 and outranks `trap_swi`, which gives base page + 0xF6.
- R6: `xirq` gives base page + 0xF4 and outranks IRQ and peripheral lines. It is ignored while `x_mask` is 1.
- R7: `irq` gives base page + 0xF2 and outranks the peripheral lines. It is ignored while `i_mask` is 1.
- R8: Peripheral line k (bit k of `mask_src`) gives base page + (0xF0 − 2k). The lowest active k wins, which is the highest offset. All of them are ignored while `i_mask` is 1.
- R9: If no unmasked source is active on the strobe edge, the result is base page + 0x10. This includes a source that dropped after being seen earlier.
- R10: The low byte of `vec_base` has no effect. Every base-relative result is `{vec_base[15:8], offset}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_por | input | 1 | Pin / power-on / low-voltage / illegal-address reset request |
| rst_clkmon | input | 1 | Clock monitor reset request |
| rst_wdog | input | 1 | Watchdog reset request |
| trap_opcode | input | 1 | Unimplemented opcode trap |
| trap_swi | input | 1 | Software interrupt or debug request |
| xirq | input | 1 | XIRQ interrupt line |
| irq | input | 1 | IRQ interrupt line |
| mask_src | input | N_MASK | Peripheral interrupt lines, bit 0 highest |
| i_mask | input | 1 | I mask: blocks IRQ and peripheral lines |
| x_mask | input | 1 | X mask: blocks XIRQ |
| vec_base | input | 16 | Vector base, upper byte used |
| vec_req | input | 1 | Vector request strobe |
| vec_valid | output | 1 | Result pulse, one cycle after a strobe |
| vec_addr | output | 16 | Registered vector address |

## Verification
Single sources are driven one at a time across every class to show that each maps to its own address. Pairs and full sets of simultaneous requests are then applied, so that a wrong priority order or a missed override shows up as a different winner. The masks are toggled under XIRQ, IRQ and peripheral traffic, which separates masked classes from the classes that must never be masked. A line that is raised and then dropped on the strobe edge, and bases with a non-zero low byte, tell the spurious fallback and the concatenated address apart from a stale or summed result.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  typedef enum logic [3:0] {
    CLS_NONE,
    CLS_POR,
    CLS_CLKMON,
    CLS_WDOG,
    CLS_OPCODE,
    CLS_SWI,
    CLS_XIRQ,
    CLS_IRQ,
    CLS_PERIPH
  } exc_cls_e;

  localparam logic [15:0] ADDR_POR    = 16'hFFFE;
  localparam logic [15:0] ADDR_CLKMON = 16'hFFFC;
  localparam logic [15:0] ADDR_WDOG   = 16'hFFFA;

  localparam logic [7:0] OFF_OPCODE   = 8'hF8;
  localparam logic [7:0] OFF_SWI      = 8'hF6;
  localparam logic [7:0] OFF_XIRQ     = 8'hF4;
  localparam logic [7:0] OFF_IRQ      = 8'hF2;
  localparam logic [7:0] OFF_PERIPH0  = 8'hF0;
  localparam logic [7:0] OFF_SPURIOUS = 8'h10;

  localparam int MAX_PERIPH = 112;

endpackage

// File: rtl/exc_periph_arb.sv
module exc_periph_arb #(
  parameter int N_MASK = 16,
  localparam int IDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1
) (
  input  logic [N_MASK-1:0] lines,
  input  logic              i_mask,
  output logic              hit,
  output logic [IDX_W-1:0]  win_idx
);

  logic [N_MASK-1:0] gated;

  generate
    for (genvar g = 0; g < N_MASK; g++) begin : g_gate
      assign gated[g] = lines[g] & ~i_mask;
    end
  endgenerate

  // Scan from the lowest-priority line up so the lowest index ends up winning.
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    for (int k = N_MASK - 1; k >= 0; k--) begin
      if (gated[k]) begin
        hit     = 1'b1;
        win_idx = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/exc_class_arb.sv
module exc_class_arb
  import exc_vec_pkg::*;
(
  input  logic     rst_por,
  input  logic     rst_clkmon,
  input  logic     rst_wdog,
  input  logic     trap_opcode,
  input  logic     trap_swi,
  input  logic     xirq,
  input  logic     irq,
  input  logic     periph_hit,
  input  logic     i_mask,
  input  logic     x_mask,
  output exc_cls_e cls
);

  always_comb begin
    if (rst_por)                cls = CLS_POR;
    else if (rst_clkmon)        cls = CLS_CLKMON;
    else if (rst_wdog)          cls = CLS_WDOG;
    else if (trap_opcode)       cls = CLS_OPCODE;
    else if (trap_swi)          cls = CLS_SWI;
    else if (xirq && !x_mask)   cls = CLS_XIRQ;
    else if (irq && !i_mask)    cls = CLS_IRQ;
    else if (periph_hit)        cls = CLS_PERIPH;
    else                        cls = CLS_NONE;
  end

endmodule

// File: rtl/exc_addr_form.sv
module exc_addr_form
  import exc_vec_pkg::*;
#(
  parameter int N_MASK = 16,
  localparam int IDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1
) (
  input  exc_cls_e         cls,
  input  logic [IDX_W-1:0] periph_idx,
  input  logic [7:0]       base_page,
  output logic [15:0]      addr
);

  logic [7:0] periph_off;
  logic [7:0] low_byte;

  assign periph_off = OFF_PERIPH0 - (8'(periph_idx) << 1);

  always_comb begin
    unique case (cls)
      CLS_OPCODE: low_byte = OFF_OPCODE;
      CLS_SWI:    low_byte = OFF_SWI;
      CLS_XIRQ:   low_byte = OFF_XIRQ;
      CLS_IRQ:    low_byte = OFF_IRQ;
      CLS_PERIPH: low_byte = periph_off;
      default:    low_byte = OFF_SPURIOUS;
    endcase
  end

  always_comb begin
    unique case (cls)
      CLS_POR:    addr = ADDR_POR;
      CLS_CLKMON: addr = ADDR_CLKMON;
      CLS_WDOG:   addr = ADDR_WDOG;
      default:    addr = {base_page, low_byte};
    endcase
  end

endmodule

// File: rtl/exc_vector_resolver.sv
module exc_vector_resolver
  import exc_vec_pkg::*;
#(
  parameter int N_MASK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_por,
  input  logic              rst_clkmon,
  input  logic              rst_wdog,
  input  logic              trap_opcode,
  input  logic              trap_swi,
  input  logic              xirq,
  input  logic              irq,
  input  logic [N_MASK-1:0] mask_src,
  input  logic              i_mask,
  input  logic              x_mask,
  input  logic [15:0]       vec_base,
  input  logic              vec_req,
  output logic              vec_valid,
  output logic [15:0]       vec_addr
);

  localparam int IDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1;

  initial begin
    if (N_MASK < 1 || N_MASK > MAX_PERIPH)
      $error("exc_vector_resolver: N_MASK out of range");
  end

  logic             periph_hit;
  logic [IDX_W-1:0] periph_idx;
  exc_cls_e         cls;
  logic [15:0]      next_addr;

  exc_periph_arb #(.N_MASK(N_MASK)) u_periph (
    .lines   (mask_src),
    .i_mask  (i_mask),
    .hit     (periph_hit),
    .win_idx (periph_idx)
  );

  exc_class_arb u_class (
    .rst_por     (rst_por),
    .rst_clkmon  (rst_clkmon),
    .rst_wdog    (rst_wdog),
    .trap_opcode (trap_opcode),
    .trap_swi    (trap_swi),
    .xirq        (xirq),
    .irq         (irq),
    .periph_hit  (periph_hit),
    .i_mask      (i_mask),
    .x_mask      (x_mask),
    .cls         (cls)
  );

  exc_addr_form #(.N_MASK(N_MASK)) u_form (
    .cls        (cls),
    .periph_idx (periph_idx),
    .base_page  (vec_base[15:8]),
    .addr       (next_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= vec_req;
      if (vec_req) vec_addr <= next_addr;
    end
  end

endmodule

// File: rtl/exc_vector_resolver_chk.sv
module exc_vector_resolver_chk #(
  parameter int N_MASK = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_por,
  input logic              rst_clkmon,
  input logic              rst_wdog,
  input logic              trap_opcode,
  input logic              trap_swi,
  input logic              xirq,
  input logic              irq,
  input logic [N_MASK-1:0] mask_src,
  input logic              i_mask,
  input logic              x_mask,
  input logic [15:0]       vec_base,
  input logic              vec_req,
  input logic              vec_valid,
  input logic [15:0]       vec_addr
);

  logic nothing_pending;
  assign nothing_pending = !rst_por && !rst_clkmon && !rst_wdog && !trap_opcode &&
                           !trap_swi && !xirq && !irq && (mask_src == '0);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_req |=> $stable(vec_addr));

  // R3
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> vec_valid);

  // R3
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_req |=> !vec_valid);

  // R4
  por_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && rst_por) |=> (vec_addr == 16'hFFFE));

  // R9
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && nothing_pending) |=> (vec_addr == {$past(vec_base[15:8]), 8'h10}));

  // R10
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[0] == 1'b0));

endmodule

bind exc_vector_resolver exc_vector_resolver_chk #(.N_MASK(N_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_por(rst_por), .rst_clkmon(rst_clkmon),
  .rst_wdog(rst_wdog), .trap_opcode(trap_opcode), .trap_swi(trap_swi),
  .xirq(xirq), .irq(irq), .mask_src(mask_src), .i_mask(i_mask),
  .x_mask(x_mask), .vec_base(vec_base), .vec_req(vec_req),
  .vec_valid(vec_valid), .vec_addr(vec_addr)
);

// File: tb/sim_exc_vector_resolver.sv
`timescale 1ns/1ps
module sim_exc_vector_resolver;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_por = 0, rst_clkmon = 0, rst_wdog = 0;
  logic trap_opcode = 0, trap_swi = 0, xirq = 0, irq = 0;
  logic [N-1:0] mask_src = '0;
  logic i_mask = 0, x_mask = 0;
  logic [15:0] vec_base = 16'h0000;
  logic vec_req = 0;
  logic vec_valid;
  logic [15:0] vec_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_vector_resolver #(.N_MASK(N)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_por(rst_por), .rst_clkmon(rst_clkmon),
    .rst_wdog(rst_wdog), .trap_opcode(trap_opcode), .trap_swi(trap_swi),
    .xirq(xirq), .irq(irq), .mask_src(mask_src), .i_mask(i_mask),
    .x_mask(x_mask), .vec_base(vec_base), .vec_req(vec_req),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  // Behavioural reference: a priority list of (pending, address) pairs.
  function automatic logic [15:0] ref_vec();
    logic [15:0] cand [$];
    bit          act  [$];
    int          off;
    act.push_back(rst_por);               cand.push_back(16'hFFFE);
    act.push_back(rst_clkmon);            cand.push_back(16'hFFFC);
    act.push_back(rst_wdog);              cand.push_back(16'hFFFA);
    act.push_back(trap_opcode);           cand.push_back({vec_base[15:8], 8'hF8});
    act.push_back(trap_swi);              cand.push_back({vec_base[15:8], 8'hF6});
    act.push_back(xirq && !x_mask);       cand.push_back({vec_base[15:8], 8'hF4});
    act.push_back(irq && !i_mask);        cand.push_back({vec_base[15:8], 8'hF2});
    for (int k = 0; k < N; k++) begin
      off = 240 - 2 * k;
      act.push_back(mask_src[k] && !i_mask);
      cand.push_back({vec_base[15:8], 8'(off)});
    end
    foreach (act[i]) if (act[i]) return cand[i];
    return {vec_base[15:8], 8'h10};
  endfunction

  logic [15:0] exp_addr  = 16'h0000;
  logic        exp_valid = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_addr  <= 16'h0000;
      exp_valid <= 1'b0;
    end else begin
      exp_valid <= vec_req;
      if (vec_req) exp_addr <= ref_vec();
    end
  end

  // Per-cycle comparison against the model (R2 hold, R3 pulse).
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (vec_addr !== exp_addr || vec_valid !== exp_valid) begin
        errors++;
        $display("FAIL R2 model: addr=%h valid=%b expected addr=%h valid=%b",
                 vec_addr, vec_valid, exp_addr, exp_valid);
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_src();
    rst_por = 0; rst_clkmon = 0; rst_wdog = 0;
    trap_opcode = 0; trap_swi = 0; xirq = 0; irq = 0; mask_src = '0;
    i_mask = 0; x_mask = 0;
  endtask

  // Strobe once; result is visible at the next falling edge.
  task automatic strobe(input string tag, input logic [15:0] exp);
    vec_req = 1;
    @(negedge clk);
    vec_req = 0;
    check(tag, vec_addr, exp);
    check({tag, " valid"}, {15'd0, vec_valid}, 16'd1);
    clear_src();
    @(negedge clk);
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset addr", vec_addr, 16'h0000);
    check("R1 reset valid", {15'd0, vec_valid}, 16'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 post-reset addr", vec_addr, 16'h0000);

    vec_base = 16'h4000;
    // R4 reset classes and their order
    rst_por = 1; rst_clkmon = 1; rst_wdog = 1; trap_opcode = 1;
    strobe("R4 por wins", 16'hFFFE);
    rst_clkmon = 1; rst_wdog = 1; xirq = 1;
    strobe("R4 clkmon", 16'hFFFC);
    rst_wdog = 1; trap_opcode = 1; irq = 1;
    strobe("R4 wdog", 16'hFFFA);

    // R5 traps, unmasked
    trap_opcode = 1; trap_swi = 1; i_mask = 1; x_mask = 1;
    strobe("R5 opcode", 16'h40F8);
    trap_swi = 1; xirq = 1; i_mask = 1; x_mask = 1;
    strobe("R5 swi", 16'h40F6);

    // R6 XIRQ and its mask
    xirq = 1; irq = 1; mask_src = 16'h0001;
    strobe("R6 xirq", 16'h40F4);
    xirq = 1; irq = 1; x_mask = 1;
    strobe("R6 xirq masked", 16'h40F2);

    // R7 IRQ and its mask
    irq = 1; mask_src = 16'h8001;
    strobe("R7 irq", 16'h40F2);
    irq = 1; i_mask = 1;
    strobe("R7 irq masked", 16'h4010);

    // R8 peripheral lines
    mask_src = 16'h0001;
    strobe("R8 line0", 16'h40F0);
    mask_src = 16'h8000;
    strobe("R8 line15", 16'h40D2);
    mask_src = 16'h0A48;
    strobe("R8 lowest index wins", 16'h40EA);
    mask_src = 16'hFFFF; i_mask = 1; xirq = 1;
    strobe("R8 masked falls to xirq", 16'h40F4);

    // R9 spurious, including a dropped source
    strobe("R9 nothing pending", 16'h4010);
    irq = 1;
    @(negedge clk);
    @(negedge clk);
    irq = 0;
    strobe("R9 dropped irq", 16'h4010);

    // R10 low byte of base ignored
    vec_base = 16'h12FF; mask_src = 16'h0004;
    strobe("R10 base low byte", 16'h12EC);
    vec_base = 16'hA5A5; trap_swi = 1;
    strobe("R10 swi base", 16'hA5F6);

    // R2 hold across idle cycles with inputs moving
    rst_por = 1; vec_base = 16'h3300;
    repeat (3) @(negedge clk);
    check("R2 hold", vec_addr, 16'hA5F6);
    clear_src();

    // Mixed traffic compared on every clock by the model
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = 32'(i) * 32'h9E3779B1;
      rst_por    = (r[31:27] == 0);
      rst_clkmon = (r[26:22] == 0);
      rst_wdog   = (r[21:17] == 1);
      trap_opcode = (r[16:14] == 0);
      trap_swi   = (r[13:11] == 0);
      xirq       = r[10];
      irq        = r[9];
      mask_src   = r[31:16] & r[15:0];
      i_mask     = r[8];
      x_mask     = r[7];
      vec_base   = r[23:8];
      vec_req    = r[3] | r[5];
      @(negedge clk);
    end
    vec_req = 0;
    clear_src();
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule